// File: doc/BRIEF.md
# AAL2 Packet Header Checker

This block inspects the header of every AAL2 CPS-packet received on one configured channel. It receives a header strobe with the channel identifier, the length indicator and the user-to-user indication, plus a silence-descriptor flag. It counts every packet, silence descriptors included. It compares the length indicator with a programmed value. It divides the low four UUI bits into a rolling sequence number and a fixed pattern that must match a programmed value.

A 5-bit selector sets the division. Its lowest set bit gives the number of sequence bits, and the UUI bits above those are the match bits. When a check fails and its report enable is set, the block writes one error record into a single-entry holding register. The register is drained with a valid/ready handshake. Every header is passed on for processing one cycle later, whatever the check results are.

Top module: `cps_hdr_checker`

## Requirements
- R1: `pkt_count` increases by one in the cycle after each `hdr_valid`, silence-descriptor packets included. It wraps from 0xFFFF to 0x0000. It does not change on cycles without a header.
- R2: When `hdr_li` differs from `cfg_exp_li` and `cfg_li_rpt_en` is 1, an error record is produced with `rpt_code` bit 0 set.
- R3: Each `hdr_valid` produces `proc_valid` = 1 in the next cycle, with `proc_sid` carrying `hdr_sid`. A length or UUI error never suppresses this.
- R4: When the UUI check fails and `cfg_uui_rpt_en` is 1, an error record is produced with `rpt_code` bit 1 set. If the same packet has both errors, a single record is produced with code 3.
- R5: The lowest set bit of `cfg_sel` at position k (0 to 4) gives k sequence bits, which are UUI[k-1:0]. The match bits are UUI[3:k] and are compared with the same bits of `cfg_exp_uui`. Higher set bits of `cfg_sel` are ignored, and so is UUI bit 4.
- R6: The expected sequence value starts at 0. After every packet it becomes the received sequence bits plus one, modulo 2^k. A packet whose sequence bits differ from the expected value is a UUI error, and the next packet is then checked against the resynchronised value.
- R7: When `cfg_sel` is 0, no UUI check is made and no UUI error is ever reported.
- R8: With both report enables at 0, no record is produced for a mismatching packet.
- R9: A record is held in `rpt_*` with `rpt_valid` = 1 until it is accepted by `rpt_ready` = 1. If a new record arrives while the held one has not been accepted, the new record is dropped and the sticky flag `rpt_overflow` is set. Each record carries the error code, CID, LI, UUI and the counter value that includes the packet.
- R10: A synchronous active-high `rst` clears the counter, the expected sequence value, `rpt_valid`, `rpt_overflow` and `proc_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 1 | Header strobe, one cycle per packet |
| hdr_cid | input | 8 | Channel identifier |
| hdr_li | input | 6 | Length indicator |
| hdr_uui | input | 5 | User-to-user indication |
| hdr_sid | input | 1 | Silence-descriptor packet flag |
| cfg_exp_li | input | 6 | Expected length indicator |
| cfg_li_rpt_en | input | 1 | Enable length-error records |
| cfg_uui_rpt_en | input | 1 | Enable UUI-error records |
| cfg_sel | input | 5 | Sequence/match selector |
| cfg_exp_uui | input | 4 | Expected UUI match value |
| pkt_count | output | 16 | Running packet count |
| proc_valid | output | 1 | Packet forwarded for processing |
| proc_sid | output | 1 | Silence flag of the forwarded packet |
| rpt_valid | output | 1 | Error record held |
| rpt_ready | input | 1 | Consumer accepts the record |
| rpt_code | output | 2 | Bit 0 length error, bit 1 UUI error |
| rpt_cid | output | 8 | CID of the reported packet |
| rpt_li | output | 6 | LI of the reported packet |
| rpt_uui | output | 5 | UUI of the reported packet |
| rpt_count | output | 16 | Counter value including the reported packet |
| rpt_overflow | output | 1 | Sticky flag: a record was dropped |

## Verification
Two situations are hard to reach from the ports. The first is the counter wrap, which needs 65,536 packets. The bench reaches it by holding the header strobe high for a long back-to-back run with matching headers. The second is the resynchronisation of the sequence number after an error, which the ports expose only through the codes of later packets. The vector table therefore places a correct packet right after each sequence error, and it changes the selector mid-stream so the masked stored value is exercised. The overflow path is reached by holding `rpt_ready` low across two faulty packets.

// File: rtl/cps_hdr_pkg.sv
package cps_hdr_pkg;
  localparam int ERR_LI_BIT  = 0;
  localparam int ERR_UUI_BIT = 1;
  localparam int CODE_W      = 2;

  // Position of the lowest set selector bit = number of sequence bits.
  function automatic int seq_bits(input logic [7:0] sel, input int sel_w);
    int n;
    n = 0;
    for (int i = sel_w - 1; i >= 0; i--)
      if (sel[i]) n = i;
    return n;
  endfunction
endpackage

// File: rtl/uui_seq_checker.sv
module uui_seq_checker
  import cps_hdr_pkg::*;
#(
  parameter int CHK_W = 4,
  parameter int UUI_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pkt_valid,
  input  logic [CHK_W:0]   sel,
  input  logic [CHK_W-1:0] exp_uui,
  input  logic [UUI_W-1:0] uui,
  output logic             uui_err
);
  localparam int SEL_W = CHK_W + 1;

  logic [CHK_W-1:0] exp_seq;
  logic [CHK_W-1:0] seq_mask;
  logic [CHK_W-1:0] rx;
  logic             chk_on;
  logic             seq_bad;
  logic             match_bad;
  int               nseq;

  always_comb begin
    nseq   = seq_bits(8'(sel), SEL_W);
    chk_on = |sel;
    rx     = uui[CHK_W-1:0];
    for (int i = 0; i < CHK_W; i++)
      seq_mask[i] = (i < nseq);
    seq_bad   = |((rx ^ exp_seq) & seq_mask);
    match_bad = |((rx ^ exp_uui) & ~seq_mask);
    uui_err   = chk_on && (seq_bad || match_bad);
  end

  always_ff @(posedge clk) begin
    if (rst)
      exp_seq <= '0;
    else if (pkt_valid)
      exp_seq <= (rx + 1'b1) & seq_mask;
  end

  // R7: a zero selector never flags a UUI error
  assert_no_check_R7: assert property (@(posedge clk) disable iff (rst)
    (sel == '0) |-> !uui_err);
  // R6: expected sequence bits never leave the active sequence field
  assert_seq_in_field_R6: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && sel[0]) |=> (exp_seq == '0));
endmodule

// File: rtl/report_hold.sv
module report_hold #(
  parameter int REC_W = 39
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [REC_W-1:0] push_data,
  input  logic             ready,
  output logic             valid,
  output logic [REC_W-1:0] data,
  output logic             overflow
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid    <= 1'b0;
      data     <= '0;
      overflow <= 1'b0;
    end else begin
      if (push && (!valid || ready)) begin
        valid <= 1'b1;
        data  <= push_data;
      end else if (valid && ready) begin
        valid <= 1'b0;
      end
      if (push && valid && !ready)
        overflow <= 1'b1;
    end
  end

  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(data)));
  assert_no_overflow_clear_R9: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
endmodule

// File: rtl/cps_hdr_checker.sv
module cps_hdr_checker
  import cps_hdr_pkg::*;
#(
  parameter int CID_W = 8,
  parameter int LI_W  = 6,
  parameter int UUI_W = 5,
  parameter int CHK_W = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hdr_valid,
  input  logic [CID_W-1:0] hdr_cid,
  input  logic [LI_W-1:0]  hdr_li,
  input  logic [UUI_W-1:0] hdr_uui,
  input  logic             hdr_sid,
  input  logic [LI_W-1:0]  cfg_exp_li,
  input  logic             cfg_li_rpt_en,
  input  logic             cfg_uui_rpt_en,
  input  logic [CHK_W:0]   cfg_sel,
  input  logic [CHK_W-1:0] cfg_exp_uui,
  output logic [CNT_W-1:0] pkt_count,
  output logic             proc_valid,
  output logic             proc_sid,
  output logic             rpt_valid,
  input  logic             rpt_ready,
  output logic [CODE_W-1:0] rpt_code,
  output logic [CID_W-1:0] rpt_cid,
  output logic [LI_W-1:0]  rpt_li,
  output logic [UUI_W-1:0] rpt_uui,
  output logic [CNT_W-1:0] rpt_count,
  output logic             rpt_overflow
);
  localparam int REC_W = CODE_W + CID_W + LI_W + UUI_W + CNT_W;

  logic              uui_err;
  logic              li_err;
  logic [CODE_W-1:0] code;
  logic [CNT_W-1:0]  count_next;
  logic              push;
  logic [REC_W-1:0]  rec_in;
  logic [REC_W-1:0]  rec_out;

  uui_seq_checker #(.CHK_W(CHK_W), .UUI_W(UUI_W)) u_uui (
    .clk(clk), .rst(rst), .pkt_valid(hdr_valid), .sel(cfg_sel),
    .exp_uui(cfg_exp_uui), .uui(hdr_uui), .uui_err(uui_err)
  );

  always_comb begin
    li_err               = (hdr_li != cfg_exp_li);
    code                 = '0;
    code[ERR_LI_BIT]     = li_err && cfg_li_rpt_en;
    code[ERR_UUI_BIT]    = uui_err && cfg_uui_rpt_en;
    count_next           = pkt_count + 1'b1;
    push                 = hdr_valid && (code != '0);
    rec_in               = {code, hdr_cid, hdr_li, hdr_uui, count_next};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_count  <= '0;
      proc_valid <= 1'b0;
      proc_sid   <= 1'b0;
    end else begin
      proc_valid <= hdr_valid;
      proc_sid   <= hdr_valid && hdr_sid;
      if (hdr_valid) pkt_count <= count_next;
    end
  end

  report_hold #(.REC_W(REC_W)) u_hold (
    .clk(clk), .rst(rst), .push(push), .push_data(rec_in), .ready(rpt_ready),
    .valid(rpt_valid), .data(rec_out), .overflow(rpt_overflow)
  );

  assign {rpt_code, rpt_cid, rpt_li, rpt_uui, rpt_count} = rec_out;

  assert_count_step_R1: assert property (@(posedge clk) disable iff (rst)
    hdr_valid |=> (pkt_count == CNT_W'($past(pkt_count) + 1'b1)));
  assert_count_hold_R1: assert property (@(posedge clk) disable iff (rst)
    !hdr_valid |=> $stable(pkt_count));
  assert_forward_R3: assert property (@(posedge clk) disable iff (rst)
    hdr_valid |=> proc_valid);
  assert_silent_R8: assert property (@(posedge clk) disable iff (rst)
    (hdr_valid && !cfg_li_rpt_en && !cfg_uui_rpt_en && !rpt_valid) |=> !rpt_valid);
endmodule

// File: tb/tb_cps_hdr_checker.sv
module tb_cps_hdr_checker;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 17;
  // {sel[4:0], uui[4:0], li[5:0], expected code[1:0]}; exp_li=20, exp_uui=4'b1010
  localparam logic [17:0] VEC [NVEC] = '{
    {5'b10000, 5'd0,       6'd20, 2'd0},  // R6 seq 0 ok
    {5'b10000, 5'd1,       6'd20, 2'd0},  // R6 seq 1 ok
    {5'b10000, 5'd5,       6'd20, 2'd2},  // R6 seq error (exp 2)
    {5'b10000, 5'd6,       6'd21, 2'd1},  // R6 resync ok, R2 LI err
    {5'b10000, 5'd3,       6'd0,  2'd3},  // R4 both errors
    {5'b00100, 5'b01000,   6'd20, 2'd0},  // R5 2 seq bits, match 10
    {5'b00100, 5'b01001,   6'd20, 2'd0},
    {5'b00100, 5'b00110,   6'd20, 2'd2},  // R5 match bits wrong
    {5'b00001, 5'b11010,   6'd20, 2'd0},  // R5 all match, bit4 ignored
    {5'b00001, 5'b01011,   6'd20, 2'd2},
    {5'b00000, 5'd0,       6'd20, 2'd0},  // R7
    {5'b00000, 5'd7,       6'd5,  2'd1},  // R7 only LI
    {5'b11010, 5'b01010,   6'd20, 2'd0},  // R5 priority: 1 seq bit
    {5'b11010, 5'b01010,   6'd20, 2'd2},  // R6 seq bit error
    {5'b11010, 5'b01011,   6'd20, 2'd0},  // R6 resync
    {5'b01000, 5'b01000,   6'd20, 2'd0},  // R5 3 seq bits
    {5'b01000, 5'b00001,   6'd20, 2'd2}   // R5 bit3 mismatch
  };

  logic clk = 0, rst = 1;
  logic hdr_valid = 0, hdr_sid = 0;
  logic [7:0] hdr_cid = 0;
  logic [5:0] hdr_li = 0, cfg_exp_li = 6'd20;
  logic [4:0] hdr_uui = 0, cfg_sel = 0;
  logic [3:0] cfg_exp_uui = 4'b1010;
  logic cfg_li_rpt_en = 1, cfg_uui_rpt_en = 1, rpt_ready = 1;
  logic [15:0] pkt_count, rpt_count;
  logic proc_valid, proc_sid, rpt_valid, rpt_overflow;
  logic [1:0] rpt_code;
  logic [7:0] rpt_cid;
  logic [5:0] rpt_li;
  logic [4:0] rpt_uui;

  int checks = 0, errors = 0;
  logic [15:0] exp_cnt = 0;

  cps_hdr_checker dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 190000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [4:0] sel, input logic [4:0] uui,
                      input logic [5:0] li, input logic [7:0] cid, input logic sid);
    cfg_sel = sel; hdr_uui = uui; hdr_li = li; hdr_cid = cid; hdr_sid = sid;
    hdr_valid = 1;
    @(negedge clk);
    hdr_valid = 0;
    exp_cnt++;
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 0;
    chk(pkt_count == 0, "R10 count", pkt_count, 0);
    chk(!rpt_valid && !rpt_overflow && !proc_valid, "R10 flags", rpt_valid, 0);

    for (int i = 0; i < NVEC; i++) begin
      send(VEC[i][17:13], VEC[i][12:8], VEC[i][7:2], 8'(i), 1'b0);
      chk(rpt_valid == (VEC[i][1:0] != 0), "R9 record valid", rpt_valid, int'(VEC[i][1:0] != 0));
      if (VEC[i][1:0] != 0) begin
        chk(rpt_code == VEC[i][1:0], "R4 R5 R6 code", rpt_code, VEC[i][1:0]);
        chk(rpt_cid == 8'(i) && rpt_count == exp_cnt, "R9 record fields", rpt_count, exp_cnt);
      end
      chk(proc_valid, "R3 forwarded", proc_valid, 1);
      chk(pkt_count == exp_cnt, "R1 count", pkt_count, exp_cnt);
    end

    // R3 silence descriptor counted and forwarded
    send(5'b0, 5'd0, 6'd20, 8'd50, 1'b1);
    chk(proc_sid && pkt_count == exp_cnt, "R3 R1 sid", pkt_count, exp_cnt);
    @(negedge clk);
    chk(!proc_valid && pkt_count == exp_cnt, "R1 R3 idle", proc_valid, 0);

    // R8 both enables off
    cfg_li_rpt_en = 0; cfg_uui_rpt_en = 0;
    send(5'b00001, 5'd0, 6'd3, 8'd60, 1'b0);
    chk(!rpt_valid, "R8 no record", rpt_valid, 0);
    chk(proc_valid, "R3 forwarded on error", proc_valid, 1);
    cfg_li_rpt_en = 1; cfg_uui_rpt_en = 1;

    // R9 overflow
    rpt_ready = 0;
    send(5'b0, 5'd0, 6'd1, 8'd71, 1'b0);
    chk(rpt_valid && rpt_cid == 71 && !rpt_overflow, "R9 held", rpt_cid, 71);
    send(5'b0, 5'd0, 6'd2, 8'd72, 1'b0);
    chk(rpt_cid == 71 && rpt_overflow, "R9 drop new", rpt_cid, 71);
    rpt_ready = 1;
    @(negedge clk);
    chk(!rpt_valid && rpt_overflow, "R9 drained sticky", rpt_overflow, 1);

    // R1 wrap
    cfg_sel = 0; hdr_li = 6'd20; hdr_sid = 0;
    hdr_valid = 1;
    while (exp_cnt != 16'hFFFF) begin
      @(negedge clk);
      exp_cnt++;
    end
    chk(pkt_count == 16'hFFFF, "R1 max", pkt_count, 16'hFFFF);
    @(negedge clk);
    hdr_valid = 0;
    chk(pkt_count == 0, "R1 wrap", pkt_count, 0);

    // R10 reset clears sticky flag and counter
    rst = 1;
    @(negedge clk);
    rst = 0;
    chk(!rpt_overflow && pkt_count == 0, "R10 reset", rpt_overflow, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule